// File: doc/BRIEF.md
# Signature match and timeout detector

This block sits at the receiving end of a packet network and checks that every data packet really arrived. A lightweight side network delivers a short look-ahead signature for each packet ahead of the packet itself. The block parks each such signature in a small associative pool, where every occupied slot runs its own age counter. When the packet shows up, its signature is recomputed upstream and presented here. It is compared against every pooled signature at once, and a hit frees the matching slot.

A slot that grows too old, a pool with no room for a new signature, or a packet signature that finds no partner within a short grace window all raise a sticky error flag. That flag is what starts system recovery. A recomputed signature that arrives before its look-ahead partner is held in a single side register for a few cycles, so that a slightly late signature still pairs with it. The error flag stays set until an explicit clear.

Top module: `sig_match_detector`

## Requirements
- R1: After a synchronous reset every pool slot and the side register are empty, and `match_o`, `err_o` and `full_o` are all 0.
- R2: A packet signature equal to a pooled entry frees that entry and drives `match_o` high for exactly the cycle after the clock edge where it was presented.
- R3: When several pooled entries hold the packet's value, only the lowest-numbered slot is freed; the others keep their ages. A new look-ahead signature always goes into the lowest-numbered free slot.
- R4: An entry stored at edge t that is not matched times out at edge t+TIMEOUT and is freed, and `err_o` is high after that edge. A match presented at edge t+TIMEOUT still wins and raises no error.
- R5: `full_o` is 1 whenever every slot is occupied. A look-ahead signature that needs a slot when no slot is free, or being freed that cycle, is dropped and sets `err_o`.
- R6: When a packet match and a new look-ahead signature occur in the same cycle, the match is handled first, so the freed slot can take the new signature without an error.
- R7: A packet signature that matches no pooled entry and no same-cycle look-ahead signature is parked in the side register. A look-ahead signature equal to it, arriving at edges t+1 to t+HOLD after parking at edge t, pulses `match_o`, clears the register and is not pooled.
- R8: A parked signature not paired by edge t+HOLD sets `err_o`. A second unmatched packet signature arriving while the register is occupied, and not freed that cycle, also sets `err_o`.
- R9: `err_o` is sticky. `err_clear_i` clears it one edge later, but a new error cause in the same cycle keeps it set.
- R10: A packet signature and a look-ahead signature with equal value in the same cycle (with no pooled hit) pair with each other: `match_o` pulses and the look-ahead value is not pooled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| la_valid_i | input | 1 | Look-ahead signature present this cycle |
| la_sig_i | input | SIG_W | Look-ahead signature value |
| pk_valid_i | input | 1 | Recomputed packet signature present this cycle |
| pk_sig_i | input | SIG_W | Recomputed packet signature value |
| err_clear_i | input | 1 | Clears the sticky error flag |
| match_o | output | 1 | One-cycle pulse when a packet was paired |
| err_o | output | 1 | Sticky error flag that starts recovery |
| full_o | output | 1 | Every pool slot is occupied |

## Verification
The bench builds the detector with a pool of 4 slots, a timeout of 20 cycles and a grace window of 3 cycles, keeping the signature width at 16. The short timeout lets exact expiry edges, duplicate-value ageing and timeouts that race a final-edge match all happen within a few dozen cycles. The small pool makes overflow and same-cycle slot reuse easy to reach. A pseudo-random phase over a tiny alphabet of signature values then drives many collisions, parks, expiries and clears, and the bench compares all three outputs to a behavioural model on every cycle.

// File: rtl/sigmd_pkg.sv
`timescale 1ns/1ps
package sigmd_pkg;

    localparam int DEF_DEPTH   = 12;
    localparam int DEF_SIG_W   = 16;
    localparam int DEF_TIMEOUT = 4000;
    localparam int DEF_HOLD    = 8;

    // What happens to a packet signature presented in a given cycle
    typedef enum logic [2:0] {
        PK_IDLE,
        PK_BUF_HIT,
        PK_LA_HIT,
        PK_PARK,
        PK_COLLIDE
    } pk_fate_e;

    // Counter width able to hold values 0 .. lim-1
    function automatic int cnt_width(input int lim);
        return (lim < 2) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/sigmd_lowest.sv
`timescale 1ns/1ps
module sigmd_lowest #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                gnt_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/sigmd_entry.sv
`timescale 1ns/1ps
module sigmd_entry
    import sigmd_pkg::*;
#(
    parameter int SIG_W   = DEF_SIG_W,
    parameter int TIMEOUT = DEF_TIMEOUT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             store_i,
    input  logic [SIG_W-1:0] store_sig_i,
    input  logic             retire_i,
    output logic             valid_o,
    output logic [SIG_W-1:0] sig_o,
    output logic             expire_o
);
    localparam int             CW   = cnt_width(TIMEOUT);
    localparam logic [CW-1:0]  LAST = CW'(TIMEOUT - 1);

    logic             valid_q;
    logic [SIG_W-1:0] sig_q;
    logic [CW-1:0]    age_q;

    assign valid_o  = valid_q;
    assign sig_o    = sig_q;
    assign expire_o = valid_q && !retire_i && (age_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            sig_q   <= '0;
            age_q   <= '0;
        end else if (store_i) begin
            valid_q <= 1'b1;
            sig_q   <= store_sig_i;
            age_q   <= '0;
        end else if (retire_i || expire_o) begin
            valid_q <= 1'b0;
            age_q   <= '0;
        end else if (valid_q) begin
            age_q   <= age_q + 1'b1;
        end
    end

    // The selector above must only free an occupied slot
    assert_retire_occupied_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        retire_i |-> valid_q);

    // A slot may only be written when it is empty or being freed this cycle
    assert_store_into_free_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        store_i |-> (!valid_q || retire_i || expire_o));
endmodule

// File: rtl/sigmd_hold.sv
`timescale 1ns/1ps
module sigmd_hold
    import sigmd_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W,
    parameter int HOLD  = DEF_HOLD
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [SIG_W-1:0] load_sig_i,
    input  logic             consume_i,
    output logic             valid_o,
    output logic [SIG_W-1:0] sig_o,
    output logic             expire_o
);
    localparam int            AW   = cnt_width(HOLD);
    localparam logic [AW-1:0] LAST = AW'(HOLD - 1);

    logic             valid_q;
    logic [SIG_W-1:0] sig_q;
    logic [AW-1:0]    age_q;

    assign valid_o  = valid_q;
    assign sig_o    = sig_q;
    assign expire_o = valid_q && !consume_i && (age_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            sig_q   <= '0;
            age_q   <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            sig_q   <= load_sig_i;
            age_q   <= '0;
        end else if (consume_i || expire_o) begin
            valid_q <= 1'b0;
            age_q   <= '0;
        end else if (valid_q) begin
            age_q   <= age_q + 1'b1;
        end
    end

    // A late pairing can only consume a parked signature
    assert_consume_parked_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        consume_i |-> valid_q);

    // Parking never overwrites a live signature
    assert_park_no_clobber_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |-> (!valid_q || consume_i || expire_o));
endmodule

// File: rtl/sig_match_detector.sv
`timescale 1ns/1ps
module sig_match_detector
    import sigmd_pkg::*;
#(
    parameter int DEPTH   = DEF_DEPTH,
    parameter int SIG_W   = DEF_SIG_W,
    parameter int TIMEOUT = DEF_TIMEOUT,
    parameter int HOLD    = DEF_HOLD
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             la_valid_i,
    input  logic [SIG_W-1:0] la_sig_i,
    input  logic             pk_valid_i,
    input  logic [SIG_W-1:0] pk_sig_i,
    input  logic             err_clear_i,
    output logic             match_o,
    output logic             err_o,
    output logic             full_o
);
    logic [DEPTH-1:0] valid_v, hit_v, retire_v, expire_v, free_v, grant_v, store_v;
    logic [SIG_W-1:0] sig_a [DEPTH];
    logic             pk_hit, has_free, pk_la, la_store, overflow;
    logic             h_valid, h_expire, h_consume;
    logic [SIG_W-1:0] h_sig;
    pk_fate_e         fate;
    logic             err_set, match_d;
    logic             err_q, match_q;

    // ---------------- pool of pending look-ahead signatures
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sigmd_entry #(.SIG_W(SIG_W), .TIMEOUT(TIMEOUT)) u_entry (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .store_i     (store_v[g]),
            .store_sig_i (la_sig_i),
            .retire_i    (retire_v[g]),
            .valid_o     (valid_v[g]),
            .sig_o       (sig_a[g]),
            .expire_o    (expire_v[g])
        );
        assign hit_v[g] = pk_valid_i && valid_v[g] && (sig_a[g] == pk_sig_i);
    end

    // lowest-numbered hit is the one retired
    sigmd_lowest #(.N(DEPTH)) u_hit_pick (
        .req_i (hit_v),
        .gnt_o (retire_v),
        .any_o (pk_hit)
    );

    // slots freed this cycle count as free for an arriving signature
    assign free_v = ~valid_v | retire_v | expire_v;

    sigmd_lowest #(.N(DEPTH)) u_free_pick (
        .req_i (free_v),
        .gnt_o (grant_v),
        .any_o (has_free)
    );

    // ---------------- side register for an early packet signature
    sigmd_hold #(.SIG_W(SIG_W), .HOLD(HOLD)) u_hold (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (fate == PK_PARK),
        .load_sig_i (pk_sig_i),
        .consume_i  (h_consume),
        .valid_o    (h_valid),
        .sig_o      (h_sig),
        .expire_o   (h_expire)
    );

    // ---------------- pairing decisions
    assign pk_la     = pk_valid_i && !pk_hit && la_valid_i && (la_sig_i == pk_sig_i);
    assign h_consume = la_valid_i && !pk_la && h_valid && (la_sig_i == h_sig);
    assign la_store  = la_valid_i && !pk_la && !h_consume;
    assign overflow  = la_store && !has_free;
    assign store_v   = grant_v & {DEPTH{la_store}};

    always_comb begin
        if (!pk_valid_i)                          fate = PK_IDLE;
        else if (pk_hit)                          fate = PK_BUF_HIT;
        else if (pk_la)                           fate = PK_LA_HIT;
        else if (!h_valid || h_consume || h_expire) fate = PK_PARK;
        else                                      fate = PK_COLLIDE;
    end

    assign err_set = (|expire_v) || overflow || h_expire || (fate == PK_COLLIDE);
    assign match_d = (fate == PK_BUF_HIT) || (fate == PK_LA_HIT) || h_consume;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            err_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            match_q <= match_d;
            if (err_set)          err_q <= 1'b1;
            else if (err_clear_i) err_q <= 1'b0;
        end
    end

    assign match_o = match_q;
    assign err_o   = err_q;
    assign full_o  = &valid_v;

    // ---------------- properties
    assert_hit_pulses_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (pk_valid_i && |hit_v) |=> match_o);

    assert_single_retire_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(retire_v) && ((retire_v & ~hit_v) == '0));

    assert_timeout_flags_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (|expire_v) |=> err_o);

    assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (la_store && full_o && ((retire_v | expire_v) == '0)) |=> err_o);

    assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_o && !err_clear_i) |=> err_o);
endmodule

// File: tb/sig_match_detector_tb.sv
`timescale 1ns/1ps
module sig_match_detector_tb;
    localparam int DEPTH   = 4;
    localparam int SIG_W   = 16;
    localparam int TIMEOUT = 20;
    localparam int HOLD    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic la_v = 1'b0, pk_v = 1'b0, clr = 1'b0;
    logic [SIG_W-1:0] la_s = '0, pk_s = '0;
    logic match, err, full;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sig_match_detector #(.DEPTH(DEPTH), .SIG_W(SIG_W), .TIMEOUT(TIMEOUT), .HOLD(HOLD)) u_dut (
        .clk_i(clk), .rst_i(rst),
        .la_valid_i(la_v), .la_sig_i(la_s),
        .pk_valid_i(pk_v), .pk_sig_i(pk_s),
        .err_clear_i(clr),
        .match_o(match), .err_o(err), .full_o(full)
    );

    // ---------------- behavioural reference
    bit mval [DEPTH];
    int msig [DEPTH];
    int mage [DEPTH];
    bit hval;
    int hsig, hage;
    bit merr, mmatch;

    always @(posedge clk) begin : model
        int hit;
        bit pkla, miss, hhit, hexp, lstore, ev, placed;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin mval[i] = 0; mage[i] = 0; msig[i] = 0; end
            hval = 0; hage = 0; hsig = 0; merr = 0; mmatch = 0;
        end else begin
            hit = -1;
            if (pk_v)
                for (int i = 0; i < DEPTH; i++)
                    if (hit < 0 && mval[i] && msig[i] == int'(pk_s)) hit = i;
            pkla   = pk_v && hit < 0 && la_v && la_s == pk_s;
            miss   = pk_v && hit < 0 && !pkla;
            hhit   = la_v && !pkla && hval && int'(la_s) == hsig;
            hexp   = hval && !hhit && hage == HOLD - 1;
            lstore = la_v && !pkla && !hhit;
            ev = 0;
            for (int i = 0; i < DEPTH; i++) begin
                if (mval[i]) begin
                    if (i == hit) mval[i] = 0;
                    else if (mage[i] == TIMEOUT - 1) begin mval[i] = 0; ev = 1; end
                    else mage[i]++;
                end
            end
            if (hhit) hval = 0;
            else if (hexp) begin hval = 0; ev = 1; end
            else if (hval) hage++;
            if (miss) begin
                if (!hval) begin hval = 1; hsig = int'(pk_s); hage = 0; end
                else ev = 1;
            end
            if (lstore) begin
                placed = 0;
                for (int i = 0; i < DEPTH; i++)
                    if (!placed && !mval[i]) begin
                        mval[i] = 1; msig[i] = int'(la_s); mage[i] = 0; placed = 1;
                    end
                if (!placed) ev = 1;
            end
            if (ev) merr = 1;
            else if (clr) merr = 0;
            mmatch = (hit >= 0) || pkla || hhit;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        bit mfull;
        if (!rst && !done) begin
            mfull = 1;
            for (int i = 0; i < DEPTH; i++) if (!mval[i]) mfull = 0;
            chk("R2 model match", match, mmatch);
            chk("R9 model err", err, merr);
            chk("R5 model full", full, mfull);
        end
    end

    task automatic cyc(input bit lv, input int ls, input bit pv, input int ps, input bit c);
        la_v = lv; la_s = ls[SIG_W-1:0]; pk_v = pv; pk_s = ps[SIG_W-1:0]; clr = c;
        @(posedge clk); #2;
        la_v = 0; pk_v = 0; clr = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic do_reset;
        rst = 1; idle(2); rst = 0;
    endtask

    task automatic fill4;
        for (int k = 1; k <= 4; k++) cyc(1, 16'h100 + k, 0, 0, 0);
    endtask

    task automatic finish_run;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int r;
        #2;
        do_reset();
        // R1: reset state
        chk("R1 match after reset", match, 1'b0);
        chk("R1 err after reset", err, 1'b0);
        chk("R1 full after reset", full, 1'b0);

        // R2: basic pairing
        cyc(1, 16'hA5A5, 0, 0, 0);
        idle(4);
        cyc(0, 0, 1, 16'hA5A5, 0);
        chk("R2 match pulse", match, 1'b1);
        idle(1);
        chk("R2 pulse is one cycle", match, 1'b0);

        // R4: exact expiry edge
        do_reset();
        cyc(1, 16'h00B0, 0, 0, 0);
        idle(TIMEOUT - 1);
        chk("R4 no error before limit", err, 1'b0);
        idle(1);
        chk("R4 error at limit", err, 1'b1);
        // R4: match on the final edge wins
        do_reset();
        cyc(1, 16'h00C0, 0, 0, 0);
        idle(TIMEOUT - 1);
        cyc(0, 0, 1, 16'h00C0, 0);
        chk("R4 final-edge match", match, 1'b1);
        chk("R4 final-edge no error", err, 1'b0);

        // R3: duplicates retire lowest slot (oldest here)
        do_reset();
        cyc(1, 16'h0AAA, 0, 0, 0);
        idle(5);
        cyc(1, 16'h0AAA, 0, 0, 0);
        cyc(0, 0, 1, 16'h0AAA, 0);
        chk("R3 duplicate match", match, 1'b1);
        idle(13);
        chk("R3 older copy retired", err, 1'b0);
        idle(5);
        chk("R3 younger copy still ageing", err, 1'b0);
        idle(1);
        chk("R3 younger copy expires", err, 1'b1);

        // R5: full and overflow
        do_reset();
        fill4();
        chk("R5 full", full, 1'b1);
        chk("R5 no error when just full", err, 1'b0);
        cyc(1, 16'h0555, 0, 0, 0);
        chk("R5 overflow error", err, 1'b1);
        cyc(0, 0, 1, 16'h0555, 0);
        chk("R5 dropped signature not pooled", match, 1'b0);

        // R6: match frees slot for same-cycle arrival
        do_reset();
        fill4();
        cyc(1, 16'h0999, 1, 16'h101, 0);
        chk("R6 match", match, 1'b1);
        chk("R6 no overflow", err, 1'b0);
        chk("R6 still full", full, 1'b1);
        cyc(0, 0, 1, 16'h0999, 0);
        chk("R6 new signature pooled", match, 1'b1);

        // R10: same-cycle pairing
        do_reset();
        cyc(1, 16'h0777, 1, 16'h0777, 0);
        chk("R10 same-cycle match", match, 1'b1);
        chk("R10 not pooled", full, 1'b0);
        cyc(0, 0, 1, 16'h0777, 0);
        chk("R10 second packet finds nothing", match, 1'b0);

        // R7: late look-ahead pairs with parked signature
        do_reset();
        cyc(0, 0, 1, 16'h0011, 0);
        chk("R7 parked no match", match, 1'b0);
        idle(HOLD - 1);
        chk("R7 no error in window", err, 1'b0);
        cyc(1, 16'h0011, 0, 0, 0);
        chk("R7 late match", match, 1'b1);
        chk("R7 no error", err, 1'b0);
        cyc(0, 0, 1, 16'h0011, 0);
        chk("R7 look-ahead was not pooled", match, 1'b0);

        // R8: parked expiry and collision
        do_reset();
        cyc(0, 0, 1, 16'h0022, 0);
        idle(HOLD - 1);
        chk("R8 before expiry", err, 1'b0);
        idle(1);
        chk("R8 parked expiry", err, 1'b1);
        do_reset();
        cyc(0, 0, 1, 16'h0031, 0);
        cyc(0, 0, 1, 16'h0032, 0);
        chk("R8 collision", err, 1'b1);

        // R9: sticky, clear, set wins
        idle(3);
        chk("R9 sticky", err, 1'b1);
        cyc(0, 0, 0, 0, 1);
        chk("R9 cleared", err, 1'b0);
        do_reset();
        fill4();
        cyc(1, 16'h0666, 0, 0, 1);
        chk("R9 set beats clear", err, 1'b1);

        // mixed traffic over a tiny alphabet
        do_reset();
        r = 32'h1234_5678;
        for (int k = 0; k < 600; k++) begin
            int a, b;
            r = r * 1103515245 + 12345;
            a = (r >>> 8) & 32'hFF;
            b = (r >>> 16) & 32'hFF;
            cyc((a % 3) == 0, b % 5, (b % 4) == 1, a % 5, (a % 47) == 3);
        end
        idle(2);
        finish_run();
    end
endmodule